// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block is a programmable down-counting timer that raises a periodic interrupt request. Software sets a 16-bit reload value and a control word through a simple synchronous register port. While the timer is enabled, the counter steps down by one on each timer tick. When a tick arrives with the counter at zero, the counter takes the reload value again and a sticky status flag is set. The period is therefore the reload value plus one tick.

The status flag drives an interrupt request when interrupts are unmasked. The request carries an 8-bit level code that software chooses, and an interrupt controller outside this block uses it to rank the request. A debug freeze input can hold the count when the freeze-control bit allows it. A read-only register shows the live count in its upper half, so software can estimate the time left before the next expiry.

Top module: `pit_timer`

## Requirements
- R1: After synchronous reset, the control register, the reload register, the live count, `irq_req` and `irq_level` are all zero.
- R2: Control bit 0 is the enable bit. While it is 0, the counter holds its value whether or not ticks arrive.
- R3: While the timer is enabled and not frozen, the counter falls by exactly one on each cycle with `tick` high. It holds on cycles with `tick` low.
- R4: A tick that finds the counter at 0 reloads the counter from the reload register and sets the status bit on the same clock edge. A reload of N therefore gives one expiry every N+1 ticks.
- R5: A write to address 1 stores bits 15:0 as the reload value and loads the counter at once. The write takes priority over a tick in the same cycle, and that tick then causes no expiry.
- R6: Control bit 1 is the freeze-control bit. When it is 1 and `freeze` is high, the counter holds. When it is 0, `freeze` has no effect.
- R7: Control bit 7 is the status bit, and a write clears it only where the written bit 7 is 1. Writing 0 to bit 7 leaves it unchanged. An expiry in the same cycle as a clearing write leaves the status set.
- R8: Control bit 2 is the interrupt-enable bit. `irq_req` is high exactly when the interrupt-enable bit and the status bit are both 1.
- R9: Control bits 15:8 hold the level code. `irq_level` shows that code while `irq_req` is high and is 0 otherwise.
- R10: Address 2 reads the live count in bits 31:16, with bits 15:0 as 0. Writes to address 2 change no state.
- R11: Address 0 reads the control word in bits 15:0, with bits 6:3 and bits 31:16 as 0. Address 1 reads the reload value in bits 15:0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer tick strobe; each high cycle is one count step |
| freeze | input | 1 | Debug freeze request |
| bus_en | input | 1 | Register write strobe qualifier |
| bus_we | input | 1 | Write enable, used while bus_en is high |
| bus_addr | input | 2 | Register address: 0 control, 1 reload, 2 live count |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 8 | Level code sent with the request |

## Verification
The bench runs every reload value from 0 to 5. It follows the counter tick by tick against an arithmetic model, so a design with an off-by-one period, or one that sets the status flag a tick early or late, shows a wrong live count or a wrong flag. Two same-cycle conflicts are forced: an expiry with a status-clear write, where a design with clear priority would lose the interrupt, and a reload write with a tick, where a design with tick priority would decrement or expire instead of loading. The bench also applies freeze both with and without the freeze-control bit, drives writes at the read-only register, and sets reserved control bits. A design that gates freeze wrongly, or that lets such writes leak into state, shows a changed count or a wrong readback.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int CNT_W   = 16;
    localparam int WDATA_W = 16;
    localparam int RDATA_W = 32;
    localparam int ADDR_W  = 2;
    localparam int LVL_W   = 8;

    // control word bit positions (LSB = 0)
    localparam int BIT_EN   = 0;
    localparam int BIT_FRZ  = 1;
    localparam int BIT_IEN  = 2;
    localparam int BIT_STAT = 7;
    localparam int LVL_LO   = 8;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_LIVE   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             status;
        logic             ien;
        logic             frz_en;
        logic             en;
    } ctrl_t;

    typedef struct packed {
        logic               we_ctrl;
        logic               we_reload;
        logic               clr_status;
        logic [WDATA_W-1:0] data;
    } bus_cmd_t;

    function automatic logic [WDATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [WDATA_W-1:0] w;
        w = '0;
        w[LVL_LO +: LVL_W] = c.level;
        w[BIT_STAT]        = c.status;
        w[BIT_IEN]         = c.ien;
        w[BIT_FRZ]         = c.frz_en;
        w[BIT_EN]          = c.en;
        return w;
    endfunction
endpackage

// File: rtl/pit_bus_port.sv
module pit_bus_port
    import pit_pkg::*;
(
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WDATA_W-1:0] bus_wdata,
    input  ctrl_t              ctrl,
    input  logic [CNT_W-1:0]   reload,
    input  logic [CNT_W-1:0]   count,
    output bus_cmd_t           cmd,
    output logic [RDATA_W-1:0] rdata
);
    localparam int PAD_W = RDATA_W - CNT_W;

    reg_sel_e sel;
    logic     wr;

    assign sel = reg_sel_e'(bus_addr);
    assign wr  = bus_en & bus_we;

    always_comb begin
        cmd            = '0;
        cmd.data       = bus_wdata;
        cmd.we_ctrl    = wr && (sel == SEL_CTRL);
        cmd.we_reload  = wr && (sel == SEL_RELOAD);
        cmd.clr_status = wr && (sel == SEL_CTRL) && bus_wdata[BIT_STAT];
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:   rdata = {{(RDATA_W-WDATA_W){1'b0}}, pack_ctrl(ctrl)};
            SEL_RELOAD: rdata = {{PAD_W{1'b0}}, reload};
            SEL_LIVE:   rdata = {count, {PAD_W{1'b0}}};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/pit_ctrl_regs.sv
module pit_ctrl_regs
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_cmd_t         cmd,
    input  logic             expire,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] reload
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= '0;
        end else begin
            if (cmd.we_ctrl) begin
                ctrl.level  <= cmd.data[LVL_LO +: LVL_W];
                ctrl.ien    <= cmd.data[BIT_IEN];
                ctrl.frz_en <= cmd.data[BIT_FRZ];
                ctrl.en     <= cmd.data[BIT_EN];
            end
            if (expire)
                ctrl.status <= 1'b1;
            else if (cmd.clr_status)
                ctrl.status <= 1'b0;
            if (cmd.we_reload)
                reload <= cmd.data[CNT_W-1:0];
        end
    end

    assert_status_set_R7: assert property (@(posedge clk) disable iff (rst)
        expire |=> ctrl.status);
    assert_w1c_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr_status && !expire) |=> !ctrl.status);
endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         expire
);
    logic at_zero;
    assign at_zero = (count == '0);
    assign expire  = step & ~load & at_zero;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (step)
            count <= at_zero ? reload_val : count - 1'b1;
    end

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(count));
    assert_reload_on_zero_R4: assert property (@(posedge clk) disable iff (rst)
        expire |=> (count == $past(reload_val)));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               freeze,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WDATA_W-1:0] bus_wdata,
    output logic [RDATA_W-1:0] bus_rdata,
    output logic               irq_req,
    output logic [LVL_W-1:0]   irq_level
);
    bus_cmd_t         cmd;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             expire;
    logic             halted;
    logic             step;

    pit_bus_port u_port (
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctrl      (ctrl),
        .reload    (reload),
        .count     (count),
        .cmd       (cmd),
        .rdata     (bus_rdata)
    );

    pit_ctrl_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .expire (expire),
        .ctrl   (ctrl),
        .reload (reload)
    );

    assign halted = ctrl.frz_en & freeze;
    assign step   = tick & ctrl.en & ~halted;

    pit_down_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .load       (cmd.we_reload),
        .load_val   (cmd.data[CNT_W-1:0]),
        .reload_val (reload),
        .count      (count),
        .expire     (expire)
    );

    assign irq_req   = ctrl.ien & ctrl.status;
    assign irq_level = irq_req ? ctrl.level : '0;

    assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.frz_en && freeze && !cmd.we_reload) |=> $stable(count));
    assert_level_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> (irq_level == '0));
endmodule

// File: tb/sim_pit_timer.sv
module sim_pit_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        freeze = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [7:0]  irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pit_timer u0 (
        .clk(clk), .rst(rst), .tick(tick), .freeze(freeze),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_level(irq_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: optional tick and optional write, launched at a falling edge
    task automatic cyc(input logic t, input logic w, input logic [1:0] a, input logic [15:0] d);
        tick = t; bus_en = w; bus_we = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        tick = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_en = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 reload", v, 0);
        rd(2'd2, v); chk("R1 live", v, 0);
        chk("R1 irq", {23'd0, irq_req, irq_level}, 0);

        // R11 reserved bits and unmapped address
        cyc(0, 1, 2'd0, 16'hFFFF);
        rd(2'd0, v); chk("R11 ctrl readback", v, 32'h0000FF07);
        rd(2'd3, v); chk("R11 addr3", v, 0);
        cyc(0, 1, 2'd0, 16'h0080);

        // R2 enable clear holds counter; R5 immediate load
        cyc(0, 1, 2'd1, 16'd5);
        rd(2'd2, v); chk("R5 immediate load", v, 32'h00050000);
        rd(2'd1, v); chk("R11 reload readback", v, 32'h00000005);
        for (int i = 0; i < 3; i++) cyc(1, 0, 2'd0, 0);
        rd(2'd2, v); chk("R2 disabled hold", v, 32'h00050000);

        // R3 no tick -> hold while enabled
        cyc(0, 1, 2'd0, 16'h0001);
        repeat (3) cyc(0, 0, 2'd0, 0);
        rd(2'd2, v); chk("R3 no tick hold", v, 32'h00050000);

        // R3/R4 sweep reload values, tick-by-tick model
        for (int n = 0; n <= 5; n++) begin
            int mc;
            cyc(0, 1, 2'd1, 16'(n));
            cyc(0, 1, 2'd0, 16'h0081);
            mc = n;
            for (int k = 0; k < 2*n + 4; k++) begin
                bit mexp;
                cyc(1, 0, 2'd0, 0);
                mexp = (mc == 0);
                mc = mexp ? n : mc - 1;
                rd(2'd2, v); chk("R3 live count", v, {16'(mc), 16'h0});
                rd(2'd0, v); chk("R4 status", {31'd0, v[7]}, {31'd0, mexp});
                if (mexp) cyc(0, 1, 2'd0, 16'h0081);
            end
        end

        // R6 freeze
        cyc(0, 1, 2'd1, 16'd10);
        cyc(0, 1, 2'd0, 16'h0083);
        freeze = 1'b1;
        for (int i = 0; i < 3; i++) cyc(1, 0, 2'd0, 0);
        rd(2'd2, v); chk("R6 frozen", v, 32'h000A0000);
        cyc(0, 1, 2'd0, 16'h0001);
        cyc(1, 0, 2'd0, 0);
        rd(2'd2, v); chk("R6 freeze ignored", v, 32'h00090000);
        freeze = 1'b0;
        cyc(1, 0, 2'd0, 0);
        rd(2'd2, v); chk("R6 unfrozen", v, 32'h00080000);

        // R10 writes to live register ignored
        cyc(0, 1, 2'd2, 16'h1234);
        rd(2'd2, v); chk("R10 live unchanged", v, 32'h00080000);
        rd(2'd1, v); chk("R10 reload unchanged", v, 32'h0000000A);
        rd(2'd0, v); chk("R10 ctrl unchanged", v, 32'h00000001);

        // R8/R9 interrupt masking and level
        cyc(0, 1, 2'd1, 16'd0);
        cyc(0, 1, 2'd0, 16'h5A01);
        cyc(1, 0, 2'd0, 0);
        #1 chk("R8 masked", {31'd0, irq_req}, 0);
        chk("R9 level quiet", {24'd0, irq_level}, 0);
        cyc(0, 1, 2'd0, 16'h5A05);
        #1 chk("R8 request", {31'd0, irq_req}, 1);
        chk("R9 level", {24'd0, irq_level}, 32'h5A);
        rd(2'd0, v); chk("R11 ctrl with status", v, 32'h00005A85);
        cyc(0, 1, 2'd0, 16'h5A05);
        #1 chk("R7 write0 keeps", {31'd0, irq_req}, 1);
        cyc(0, 1, 2'd0, 16'h5A85);
        #1 chk("R7 w1c clears", {31'd0, irq_req}, 0);
        chk("R9 level cleared", {24'd0, irq_level}, 0);

        // R7 expiry wins over clear (counter at 0, reload 0)
        cyc(1, 1, 2'd0, 16'h5A85);
        #1 chk("R7 set wins", {31'd0, irq_req}, 1);
        cyc(0, 1, 2'd0, 16'h5A85);

        // R5 reload write beats tick, no expiry
        cyc(1, 1, 2'd1, 16'd7);
        rd(2'd2, v); chk("R5 load priority", v, 32'h00070000);
        #1 chk("R5 no expiry", {31'd0, irq_req}, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule